// File: doc/BRIEF.md
# Latency-Aware Register Hazard Scoreboard

This block sits at the dispatch point of an in-order pipeline. It decides, one instruction at a time, whether the instruction may leave dispatch or must wait. For each architectural register it keeps the class of the most recent writer, the number of cycles since that write, and the number of dispatch groups accepted since that write. A source operand is blocked until the cycles since its producer reach a delay that depends on both the producer class and the consumer class. A destination is blocked until enough groups have been dispatched since the previous writer, for the writer classes that impose such spacing.

A separate busy counter covers the long non-pipelined operations (multiplies, divides, square root, condition-register read). While one of these runs, all execution resources are reserved and every dispatch attempt stalls. Each accepted dispatch counts as one group. The block does no forwarding, holds no operand values and has no flush input.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset every register counts as ready and free to rewrite, the busy counter is clear, and `stall` and `issue` are low while `dispValid` is low.
- R2: `stall` is only raised while `dispValid` is high. `issue` is high exactly when `dispValid` is high and `stall` is low. A stalled attempt changes no state and does not count as a dispatch group.
- R3: Class codes on `dispClass` are 0 integer, 1 compare, 2 load, 3 float load, 4 float arithmetic, 5 float compare, 6 vector simple, 7 vector complex, 8 vector float, 9 vector estimate, 10 move-to-count, 11 branch, 12 count-register branch, 13 condition-register logical, 14 mul64, 15 mul32, 16 short multiply, 17 div32, 18 div64, 19 float divide, 20 square root, 21 condition-register read. Only the producer class sets the base delay, in cycles from the producer's dispatch cycle to the first cycle a consumer may dispatch: integer 2, load 2, float arithmetic 10, vector simple 4, vector complex 10, vector float 12, vector estimate 12, and 1 for the other pipelined classes.
- R4: An integer result read by a load, and a load result read by another load, need 5 cycles.
- R5: A float-compare result needs 6 cycles before a branch, a count-register branch, a condition-register logical op or a condition-register read may use it.
- R6: A vector-float result needs 11 cycles before another vector float and 3 cycles before a vector complex. A vector-complex result needs 6 cycles before a vector simple op.
- R7: A move-to-count result needs 10 cycles before a count-register branch. Other consumers use the base delay of 1.
- R8: A register written by a vector estimate, vector float or vector complex op may not be written again until 10, 8 or 5 groups have been accepted after that write. Idle cycles do not count as groups.
- R9: A float load may not write a register last written by float arithmetic until 6 groups have been accepted after that write. Other writer classes are not held back by a float-arithmetic target.
- R10: A non-pipelined op of latency L stalls every dispatch attempt in the L-1 cycles after its own dispatch. L is 15 for mul64, 9 for mul32, 6 for short multiply, 32 for div32, 64 for div64, 74 for float divide, 84 for square root and 34 for condition-register read.
- R11: A source or destination whose valid flag is low is never checked for a hazard.
- R12: An accepted write replaces the register's writer class and restarts its cycle and group counts. Later hazard checks use the new writer's class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | An instruction is offered for dispatch |
| dispClass | input | 5 | Class code of the offered instruction (R3) |
| dispDst | input | IDX_W | Destination register index |
| dispDstValid | input | 1 | Destination is written |
| dispSrcA | input | IDX_W | First source register index |
| dispSrcAValid | input | 1 | First source is read |
| dispSrcB | input | IDX_W | Second source register index |
| dispSrcBValid | input | 1 | Second source is read |
| stall | output | 1 | Offered instruction must wait |
| issue | output | 1 | Offered instruction is accepted at this clock edge |

## Verification
Read-after-write timing is swept over twenty producer/consumer pairs. Each pair has a fresh producer, a probe after each number of idle cycles from 0 to 13, and operands on either source port. This separates the pair-specific delays from the base delays and finds off-by-one errors at each boundary. Write-after-write spacing is swept by the number of accepted filler groups, from 0 to 11, for four previous-writer classes and two new-writer classes. Because the fillers follow a long idle gap, this shows that groups are counted and cycles are not. Each non-pipelined class is timed cycle by cycle to its exact stall length. Targeted sequences cover the valid flags being ignored, stalled attempts that leave no trace, and a rewrite that replaces the writer class.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  localparam int CLS_W = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT      = 5'd0,
    CLS_CMP      = 5'd1,
    CLS_LOAD     = 5'd2,
    CLS_FPLOAD   = 5'd3,
    CLS_FPARITH  = 5'd4,
    CLS_FPCMP    = 5'd5,
    CLS_VSIMPLE  = 5'd6,
    CLS_VCOMPLEX = 5'd7,
    CLS_VFLOAT   = 5'd8,
    CLS_VEST     = 5'd9,
    CLS_MTCTR    = 5'd10,
    CLS_BRANCH   = 5'd11,
    CLS_CTRBR    = 5'd12,
    CLS_CRLOGIC  = 5'd13,
    CLS_MUL64    = 5'd14,
    CLS_MUL32    = 5'd15,
    CLS_MULSH    = 5'd16,
    CLS_DIV32    = 5'd17,
    CLS_DIV64    = 5'd18,
    CLS_FDIV     = 5'd19,
    CLS_FSQRT    = 5'd20,
    CLS_CRREAD   = 5'd21
  } opClass_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic     issue;
    logic     writeDst;
    opClass_e wrClass;
  } lsbStrobe_t;

  function automatic logic isNonPipe(opClass_e c);
    return (c inside {CLS_MUL64, CLS_MUL32, CLS_MULSH, CLS_DIV32,
                      CLS_DIV64, CLS_FDIV, CLS_FSQRT, CLS_CRREAD});
  endfunction

  // Total cycles a non-pipelined op holds every unit
  function automatic int unsigned npLatency(opClass_e c);
    int unsigned l;
    case (c)
      CLS_MUL64:  l = 15;
      CLS_MUL32:  l = 9;
      CLS_MULSH:  l = 6;
      CLS_DIV32:  l = 32;
      CLS_DIV64:  l = 64;
      CLS_FDIV:   l = 74;
      CLS_FSQRT:  l = 84;
      CLS_CRREAD: l = 34;
      default:    l = 1;
    endcase
    return l;
  endfunction

  // Producer-only delay; non-pipelined producers are covered by the busy counter
  function automatic int unsigned baseLat(opClass_e p);
    int unsigned l;
    case (p)
      CLS_INT, CLS_LOAD:                    l = 2;
      CLS_VSIMPLE:                          l = 4;
      CLS_FPARITH, CLS_VCOMPLEX:            l = 10;
      CLS_VFLOAT, CLS_VEST:                 l = 12;
      default:                              l = isNonPipe(p) ? 0 : 1;
    endcase
    return l;
  endfunction

  // Producer/consumer pair delay in cycles after the producer's dispatch
  function automatic int unsigned rawDelay(opClass_e p, opClass_e c);
    int unsigned d;
    d = baseLat(p);
    case (p)
      CLS_INT:      if (c == CLS_LOAD) d = 5;
      CLS_LOAD:     if (c == CLS_LOAD) d = 5;
      CLS_FPCMP:    if (c inside {CLS_BRANCH, CLS_CTRBR, CLS_CRLOGIC, CLS_CRREAD}) d = 6;
      CLS_VFLOAT:   begin
                      if (c == CLS_VFLOAT) d = 11;
                      else if (c == CLS_VCOMPLEX) d = 3;
                    end
      CLS_VCOMPLEX: if (c == CLS_VSIMPLE) d = 6;
      CLS_MTCTR:    if (c == CLS_CTRBR) d = 10;
      default:      ;
    endcase
    return d;
  endfunction

  // Dispatch groups that must pass before a register may be written again
  function automatic int unsigned wawLimit(opClass_e prev, opClass_e nxt);
    int unsigned g;
    case (prev)
      CLS_VEST:     g = 10;
      CLS_VFLOAT:   g = 8;
      CLS_VCOMPLEX: g = 5;
      CLS_FPARITH:  g = (nxt == CLS_FPLOAD) ? 6 : 0;
      default:      g = 0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lsb_regfile.sv
module lsb_regfile
  import lsb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int AGE_W    = 4,
  parameter int GRP_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lsbStrobe_t       strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic [IDX_W-1:0] srcBIdx,
  output logic [AGE_W-1:0] srcAAge,
  output opClass_e         srcAClass,
  output logic [AGE_W-1:0] srcBAge,
  output opClass_e         srcBClass,
  output logic [GRP_W-1:0] dstGrp,
  output opClass_e         dstClass
);

  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [GRP_W-1:0] GRP_MAX = {GRP_W{1'b1}};

  logic [AGE_W-1:0] ageArr [NUM_REGS];
  logic [GRP_W-1:0] grpArr [NUM_REGS];
  opClass_e         clsArr [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [AGE_W-1:0] ageQ;
    logic [GRP_W-1:0] grpQ;
    opClass_e         clsQ;
    logic             hit;

    assign hit = strobe.writeDst && (wrIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ageQ <= AGE_MAX;
        grpQ <= GRP_MAX;
        clsQ <= CLS_INT;
      end else if (hit) begin
        ageQ <= AGE_W'(1);
        grpQ <= '0;
        clsQ <= strobe.wrClass;
      end else begin
        if (ageQ != AGE_MAX) ageQ <= ageQ + AGE_W'(1);
        if (strobe.issue && (grpQ != GRP_MAX)) grpQ <= grpQ + GRP_W'(1);
      end
    end

    assign ageArr[i] = ageQ;
    assign grpArr[i] = grpQ;
    assign clsArr[i] = clsQ;
  end

  assign srcAAge   = ageArr[srcAIdx];
  assign srcAClass = clsArr[srcAIdx];
  assign srcBAge   = ageArr[srcBIdx];
  assign srcBClass = clsArr[srcBIdx];
  assign dstGrp    = grpArr[wrIdx];
  assign dstClass  = clsArr[wrIdx];

endmodule

// File: rtl/lsb_ctrl.sv
module lsb_ctrl
  import lsb_pkg::*;
#(
  parameter int AGE_W  = 4,
  parameter int GRP_W  = 4,
  parameter int BUSY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dispValid,
  input  opClass_e          dispCls,
  input  logic              dstValid,
  input  logic              srcAValid,
  input  logic              srcBValid,
  input  logic [AGE_W-1:0]  srcAAge,
  input  opClass_e          srcAClass,
  input  logic [AGE_W-1:0]  srcBAge,
  input  opClass_e          srcBClass,
  input  logic [GRP_W-1:0]  dstGrp,
  input  opClass_e          dstClass,
  output logic              stall,
  output lsbStrobe_t        strobe,
  output logic [BUSY_W-1:0] busyCnt
);

  logic [BUSY_W-1:0] busyQ;
  logic rawA, rawB, waw, busyHit, accept;

  assign rawA    = srcAValid && (32'(srcAAge) < rawDelay(srcAClass, dispCls));
  assign rawB    = srcBValid && (32'(srcBAge) < rawDelay(srcBClass, dispCls));
  assign waw     = dstValid  && (32'(dstGrp)  < wawLimit(dstClass, dispCls));
  assign busyHit = (busyQ != '0);

  assign stall  = dispValid && (rawA || rawB || waw || busyHit);
  assign accept = dispValid && !stall;

  always_comb begin
    strobe          = '0;
    strobe.issue    = accept;
    strobe.writeDst = accept && dstValid;
    strobe.wrClass  = dispCls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= '0;
    end else if (accept && isNonPipe(dispCls)) begin
      busyQ <= BUSY_W'(npLatency(dispCls) - 1);
    end else if (busyHit) begin
      busyQ <= busyQ - BUSY_W'(1);
    end
  end

  assign busyCnt = busyQ;

endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
  import lsb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int AGE_W    = 4,
  parameter int GRP_W    = 4,
  parameter int BUSY_W   = 7,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dispValid,
  input  logic [4:0]       dispClass,
  input  logic [IDX_W-1:0] dispDst,
  input  logic             dispDstValid,
  input  logic [IDX_W-1:0] dispSrcA,
  input  logic             dispSrcAValid,
  input  logic [IDX_W-1:0] dispSrcB,
  input  logic             dispSrcBValid,
  output logic             stall,
  output logic             issue
);

  opClass_e          dispCls;
  lsbStrobe_t        strobe;
  logic [AGE_W-1:0]  srcAAge, srcBAge;
  opClass_e          srcAClass, srcBClass, dstClass;
  logic [GRP_W-1:0]  dstGrp;
  logic [BUSY_W-1:0] busyCnt;

  assign dispCls = opClass_e'(dispClass);

  lsb_regfile #(
    .NUM_REGS (NUM_REGS),
    .AGE_W    (AGE_W),
    .GRP_W    (GRP_W)
  ) u_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrIdx     (dispDst),
    .srcAIdx   (dispSrcA),
    .srcBIdx   (dispSrcB),
    .srcAAge   (srcAAge),
    .srcAClass (srcAClass),
    .srcBAge   (srcBAge),
    .srcBClass (srcBClass),
    .dstGrp    (dstGrp),
    .dstClass  (dstClass)
  );

  lsb_ctrl #(
    .AGE_W  (AGE_W),
    .GRP_W  (GRP_W),
    .BUSY_W (BUSY_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dispValid (dispValid),
    .dispCls   (dispCls),
    .dstValid  (dispDstValid),
    .srcAValid (dispSrcAValid),
    .srcBValid (dispSrcBValid),
    .srcAAge   (srcAAge),
    .srcAClass (srcAClass),
    .srcBAge   (srcBAge),
    .srcBClass (srcBClass),
    .dstGrp    (dstGrp),
    .dstClass  (dstClass),
    .stall     (stall),
    .strobe    (strobe),
    .busyCnt   (busyCnt)
  );

  assign issue = strobe.issue;

endmodule

// File: rtl/lat_scoreboard_chk.sv
module lat_scoreboard_chk
  import lsb_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int BUSY_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dispValid,
  input logic [4:0]        dispClass,
  input logic [IDX_W-1:0]  dispDst,
  input logic              dispDstValid,
  input logic [IDX_W-1:0]  dispSrcA,
  input logic              dispSrcAValid,
  input logic              stall,
  input logic              issue,
  input logic [BUSY_W-1:0] busyCnt
);

  a_r2_no_stall_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dispValid |-> !stall);

  a_r10_nonpipe_blocks_next: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && isNonPipe(opClass_e'(dispClass))) |=> (!dispValid || stall));

  a_r10_busy_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busyCnt != '0) |=> (busyCnt == $past(busyCnt) - BUSY_W'(1)));

  a_r3_int_not_ready_next: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dispDstValid && (dispClass == CLS_INT)) |=>
      (!(dispValid && dispSrcAValid && (dispSrcA == $past(dispDst))) || stall));

  a_r8_vfloat_rewrite_held: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dispDstValid && (dispClass == CLS_VFLOAT)) |=>
      (!(dispValid && dispDstValid && (dispDst == $past(dispDst))) || stall));

endmodule

bind lat_scoreboard lat_scoreboard_chk #(.IDX_W(IDX_W), .BUSY_W(BUSY_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dispValid     (dispValid),
  .dispClass     (dispClass),
  .dispDst       (dispDst),
  .dispDstValid  (dispDstValid),
  .dispSrcA      (dispSrcA),
  .dispSrcAValid (dispSrcAValid),
  .stall         (stall),
  .issue         (issue),
  .busyCnt       (busyCnt)
);

// File: tb/lat_scoreboard_tb.sv
`timescale 1ns/1ps
module lat_scoreboard_tb;

  localparam int C_INT = 0, C_CMP = 1, C_LOAD = 2, C_FPLOAD = 3, C_FPARITH = 4,
                 C_FPCMP = 5, C_VSIMPLE = 6, C_VCOMPLEX = 7, C_VFLOAT = 8,
                 C_VEST = 9, C_MTCTR = 10, C_BRANCH = 11, C_CTRBR = 12,
                 C_CRLOGIC = 13, C_CRREAD = 21;

  logic clk = 0;
  logic rst_n = 0;
  logic dispValid = 0;
  logic [4:0] dispClass = 0;
  logic [4:0] dispDst = 0, dispSrcA = 0, dispSrcB = 0;
  logic dispDstValid = 0, dispSrcAValid = 0, dispSrcBValid = 0;
  logic stall, issue;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lat_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n), .dispValid(dispValid), .dispClass(dispClass),
    .dispDst(dispDst), .dispDstValid(dispDstValid),
    .dispSrcA(dispSrcA), .dispSrcAValid(dispSrcAValid),
    .dispSrcB(dispSrcB), .dispSrcBValid(dispSrcBValid),
    .stall(stall), .issue(issue)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(int cls, int dst, bit dv, int a, bit av, int b, bit bv);
    dispClass = 5'(cls); dispDst = 5'(dst); dispDstValid = dv;
    dispSrcA = 5'(a); dispSrcAValid = av; dispSrcB = 5'(b); dispSrcBValid = bv;
    dispValid = 1;
  endtask

  // Accepted dispatch: waits through any stall, returns just after the accepting edge
  task automatic dispatch(int cls, int dst, bit dv, int a, bit av, int b, bit bv);
    @(negedge clk);
    drive(cls, dst, dv, a, av, b, bv);
    #1;
    while (stall) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    dispValid = 0;
  endtask

  // Look at stall for one offered instruction, withdrawn before the edge
  task automatic probe(int cls, int dst, bit dv, int a, bit av, int b, bit bv,
                       output bit st, output bit is);
    @(negedge clk);
    drive(cls, dst, dv, a, av, b, bv);
    #1;
    st = stall;
    is = issue;
    dispValid = 0;
  endtask

  task automatic flush();
    repeat (12) dispatch(C_INT, 31, 1, 0, 0, 0, 0);
    repeat (16) @(posedge clk);
  endtask

  int prodL [20] = '{C_INT, C_CMP, C_LOAD, C_FPARITH, C_VSIMPLE, C_VFLOAT, C_VEST,
                     C_INT, C_LOAD, C_FPCMP, C_FPCMP, C_FPCMP, C_VFLOAT, C_VFLOAT,
                     C_VCOMPLEX, C_VCOMPLEX, C_MTCTR, C_MTCTR, C_FPCMP, C_FPCMP};
  int consL [20] = '{C_INT, C_INT, C_INT, C_FPARITH, C_VSIMPLE, C_INT, C_VSIMPLE,
                     C_LOAD, C_LOAD, C_BRANCH, C_CRREAD, C_INT, C_VFLOAT, C_VCOMPLEX,
                     C_VSIMPLE, C_VCOMPLEX, C_CTRBR, C_BRANCH, C_CTRBR, C_CRLOGIC};
  int delL  [20] = '{2, 1, 2, 10, 4, 12, 12, 5, 5, 6, 6, 1, 11, 3, 6, 10, 10, 1, 6, 6};
  string reqL [20] = '{"R3", "R3", "R3", "R3", "R3", "R3", "R3", "R4", "R4", "R5",
                       "R5", "R3", "R6", "R6", "R6", "R3", "R7", "R7", "R5", "R5"};

  int npCls [8] = '{14, 15, 16, 17, 18, 19, 20, 21};
  int npLat [8] = '{15, 9, 6, 32, 64, 74, 84, 34};

  function automatic int expWaw(int prev, int nxt);
    if (prev == C_VEST) return 10;       // R8
    if (prev == C_VFLOAT) return 8;      // R8
    if (prev == C_VCOMPLEX) return 5;    // R8
    if (prev == C_FPARITH && nxt == C_FPLOAD) return 6; // R9
    return 0;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit st, is;
    int cnt;
    int wp [4];
    int wn [2];
    wp = '{C_VEST, C_VFLOAT, C_VCOMPLEX, C_FPARITH};
    wn = '{C_INT, C_FPLOAD};

    repeat (3) @(posedge clk);
    #1;
    check(stall == 0 && issue == 0, "R1 idle in reset", {stall, issue}, 0);
    rst_n = 1;
    @(posedge clk);
    #1;
    check(stall == 0 && issue == 0, "R1 idle after reset", {stall, issue}, 0);

    // R1: every register ready and rewritable after reset
    cnt = 0;
    for (int r = 0; r < 32; r++) begin
      probe(C_VFLOAT, r, 1, r, 1, 31 - r, 1, st, is);
      if (st) cnt++;
    end
    check(cnt == 0, "R1 all registers free", cnt, 0);

    // R3..R7: read-after-write delay sweeps per producer/consumer pair
    for (int p = 0; p < 20; p++) begin
      for (int w = 0; w < 14; w++) begin
        flush();
        dispatch(prodL[p], 3, 1, 0, 0, 0, 0);
        repeat (w) @(posedge clk);
        if (w % 2 == 0) probe(consL[p], 0, 0, 3, 1, 0, 0, st, is);
        else            probe(consL[p], 0, 0, 0, 0, 3, 1, st, is);
        check(st == ((1 + w) < delL[p]), reqL[p], st, int'((1 + w) < delL[p]));
      end
    end

    // R8 R9: write-after-write spacing counted in accepted groups
    for (int a = 0; a < 4; a++) begin
      for (int n = 0; n < 2; n++) begin
        for (int k = 0; k < 12; k++) begin
          flush();
          dispatch(wp[a], 5, 1, 0, 0, 0, 0);
          repeat (16) @(posedge clk);
          repeat (k) dispatch(C_INT, 31, 1, 0, 0, 0, 0);
          probe(wn[n], 5, 1, 0, 0, 0, 0, st, is);
          if (wp[a] == C_FPARITH)
            check(st == (k < expWaw(wp[a], wn[n])), "R9 float load reuse", st,
                  int'(k < expWaw(wp[a], wn[n])));
          else
            check(st == (k < expWaw(wp[a], wn[n])), "R8 vector reuse", st,
                  int'(k < expWaw(wp[a], wn[n])));
        end
      end
    end

    // R10: each non-pipelined op stalls for L-1 cycles after dispatch
    for (int c = 0; c < 8; c++) begin
      flush();
      dispatch(npCls[c], 7, 1, 0, 0, 0, 0);
      cnt = 0;
      for (int w = 0; w <= npLat[c]; w++) begin
        probe(C_INT, 0, 0, 0, 0, 0, 0, st, is);
        if (st) cnt++;
      end
      check(cnt == npLat[c] - 1, "R10 nonpipe stall length", cnt, npLat[c] - 1);
      check(st == 0, "R10 released after latency", st, 0);
    end

    // R2: no stall while idle even when busy; issue follows a clean offer
    flush();
    dispatch(14, 7, 1, 0, 0, 0, 0);
    @(negedge clk);
    #1;
    check(stall == 0, "R2 no stall without valid", stall, 0);
    repeat (20) @(posedge clk);
    probe(C_INT, 30, 1, 0, 0, 0, 0, st, is);
    check(is == 1 && st == 0, "R2 issue on clean offer", is, 1);

    // R2: a held stalled write counts no groups
    flush();
    dispatch(C_VFLOAT, 9, 1, 0, 0, 0, 0);
    @(negedge clk);
    drive(C_VFLOAT, 9, 1, 0, 0, 0, 0);
    repeat (5) @(posedge clk);
    #1;
    dispValid = 0;
    repeat (7) dispatch(C_INT, 31, 1, 0, 0, 0, 0);
    probe(C_VFLOAT, 9, 1, 0, 0, 0, 0, st, is);
    check(st == 1, "R2 stalled attempts not counted", st, 1);
    dispatch(C_INT, 31, 1, 0, 0, 0, 0);
    probe(C_VFLOAT, 9, 1, 0, 0, 0, 0, st, is);
    check(st == 0, "R2 window closes after eighth group", st, 0);

    // R11: invalid operands are not checked
    flush();
    dispatch(C_VFLOAT, 8, 1, 0, 0, 0, 0);
    probe(C_INT, 8, 0, 8, 0, 8, 0, st, is);
    check(st == 0, "R11 invalid operands ignored", st, 0);
    probe(C_INT, 0, 0, 8, 1, 0, 0, st, is);
    check(st == 1, "R11 valid source checked", st, 1);
    probe(C_INT, 8, 1, 0, 0, 0, 0, st, is);
    check(st == 1, "R11 valid destination checked", st, 1);

    // R12: a rewrite replaces the writer class
    flush();
    dispatch(C_VCOMPLEX, 6, 1, 0, 0, 0, 0);
    repeat (5) dispatch(C_INT, 31, 1, 0, 0, 0, 0);
    probe(C_INT, 6, 1, 0, 0, 0, 0, st, is);
    check(st == 0, "R12 rewrite allowed", st, 0);
    dispatch(C_INT, 6, 1, 0, 0, 0, 0);
    probe(C_VSIMPLE, 0, 0, 6, 1, 0, 0, st, is);
    check(st == 1, "R12 new writer one cycle", st, 1);
    probe(C_VSIMPLE, 0, 0, 6, 1, 0, 0, st, is);
    check(st == 0, "R12 new writer delay used", st, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule